// File: doc/BRIEF.md
# RTC Interrupt Flag Register with Clear-on-Read

This block holds the interrupt state of a real-time clock. Three event pulses come in from elsewhere in the clock: a periodic tick, an alarm match and the end of an update cycle. Each pulse sets a sticky flag of its own, whether or not that source is enabled. A three-bit enable register selects which flags may raise the interrupt. The OR of each flag ANDed with its enable forms a summary bit. The summary bit drives the pull-down of an open-drain, active-low interrupt pin.

Software reads the status byte through a two-phase read cycle. A start strobe latches a snapshot of the flags and the summary bit. That snapshot stays on the read-data port, unchanged, until the next read starts. A release strobe ends the cycle and clears every flag. Events that arrive between the start and the release (both cycles included) are not lost. They are parked in a per-source pending bit and land in the flags at the release. A rising edge on the clock's hold-updates control clears the update-ended enable.

Top module: `rtc_irq_flags`

## Requirements
- R1: Status bit 7 of the snapshot is the summary bit: (periodic flag AND periodic enable) OR (alarm flag AND alarm enable) OR (update flag AND update enable), taken in the cycle the read starts.
- R2: `irq_pull_low` is 1 (pin driven low) exactly when the summary of the current flags and enables is 1, and 0 (pin released to high impedance) otherwise. Out of reset it is 0.
- R3: An event pulse outside a read cycle sets its flag one clock later, whatever its enable bit holds.
- R4: The clock edge that accepts the release strobe clears all three flags, and with them the summary bit and `irq_pull_low`, unless an event is deferred.
- R5: The snapshot on `rd_data` does not change from the cycle after the start strobe until the next accepted start strobe. The flags do not change during the read.
- R6: An event that arrives in the start cycle, during the read, or in the release cycle is held. It sets its flag at the release edge and is not part of the snapshot.
- R7: Writing 1 to an enable bit whose flag is already set drives `irq_pull_low` high one clock after the write.
- R8: Status bits 3..0 always read 0.
- R9: A 0-to-1 change of `hold_updates` clears the update-ended enable one clock later. This wins over an enable write in the same cycle. A level held at 1 does not block later writes.
- R10: Status layout: periodic flag at bit 6, alarm flag at bit 5, update flag at bit 4. The enable write data uses bit 0 for periodic, bit 1 for alarm and bit 2 for update.
- R11: A release strobe outside a read has no effect. A start strobe during a read neither retakes the snapshot nor clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | Periodic tick event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 3 | Enable write data (bit0 periodic, bit1 alarm, bit2 update) |
| hold_updates | input | 1 | Hold-updates control level; its rising edge clears the update enable |
| rd_start | input | 1 | Status read start strobe |
| rd_end | input | 1 | Status read release strobe |
| rd_data | output | 8 | Latched status snapshot |
| irq_pull_low | output | 1 | Open-drain pull-down enable of the active-low interrupt pin |

## Verification
All state sits one register away from the inputs:
- A start strobe presents its snapshot after one clock edge.
- An event, an enable write or a hold edge changes `irq_pull_low` after one edge.
- A release clears the flags at that same edge.

The bench drives every input just after a falling edge. Each expected value goes into its scoreboard queue tagged with a due cycle one edge later. The monitor compares at the falling edge of that cycle, so every check samples a settled value. Deferred events are placed in the start cycle, in the middle of a read and in the release cycle. The bench then sees them only in the snapshot of the following read.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;

    localparam int NSRC   = 3;
    localparam int STAT_W = 8;

    // source index into flag / enable vectors
    localparam int SRC_PER = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_UPD = 2;

    // status byte positions
    localparam int BIT_SUM = 7;
    localparam int BIT_PER = 6;
    localparam int BIT_ALM = 5;
    localparam int BIT_UPD = 4;
    localparam int RSV_W   = BIT_UPD;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef struct packed {
        logic start;   // accepted start strobe this cycle
        logic fin;     // accepted release strobe this cycle
        logic hold;    // events must be deferred this cycle
    } rdctl_t;

    function automatic logic irq_summary(srcvec_t flg, srcvec_t en);
        return |(flg & en);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(logic sum, srcvec_t flg);
        logic [STAT_W-1:0] s;
        s          = '0;
        s[BIT_SUM] = sum;
        s[BIT_PER] = flg[SRC_PER];
        s[BIT_ALM] = flg[SRC_ALM];
        s[BIT_UPD] = flg[SRC_UPD];
        return s;
    endfunction

endpackage

// File: rtl/rtcirq_flag_cell.sv
module rtcirq_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic hold,
    input  logic fin,
    output logic flag,
    output logic pend
);
    logic flag_q, pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (fin) begin
            flag_q <= pend_q | evt;
            pend_q <= 1'b0;
        end else if (hold) begin
            if (evt) pend_q <= 1'b1;
        end else if (evt) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;
    assign pend = pend_q;

    // R3
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !hold && !fin) |=> flag_q);

    // R5
    flag_frozen_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !fin) |=> $stable(flag_q));

    // R6
    deferred_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && (pend_q || evt)) |=> flag_q);

endmodule

// File: rtl/rtcirq_enable_reg.sv
module rtcirq_enable_reg
    import rtcirq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_wr,
    input  srcvec_t en_wdata,
    input  logic    hold_updates,
    output srcvec_t en
);
    srcvec_t en_q;
    logic    hold_prev_q;
    logic    hold_rise;
    srcvec_t upd_mask;

    assign hold_rise = hold_updates & ~hold_prev_q;

    always_comb begin
        upd_mask          = '1;
        upd_mask[SRC_UPD] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= '0;
            hold_prev_q <= 1'b0;
        end else begin
            hold_prev_q <= hold_updates;
            if (hold_rise)
                en_q <= (en_wr ? en_wdata : en_q) & upd_mask;
            else if (en_wr)
                en_q <= en_wdata;
        end
    end

    assign en = en_q;

    // R9
    hold_rise_clears_upd_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_updates && !hold_prev_q) |=> !en_q[SRC_UPD]);

    // R10
    en_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !(hold_updates && !hold_prev_q)) |=> (en_q == $past(en_wdata)));

endmodule

// File: rtl/rtcirq_read_ctrl.sv
module rtcirq_read_ctrl
    import rtcirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic              rd_end,
    input  srcvec_t           flags,
    input  logic              summary,
    output rdctl_t            ctl,
    output logic [STAT_W-1:0] rd_data
);
    logic              in_read_q;
    logic [STAT_W-1:0] snap_q;

    always_comb begin
        ctl.start = rd_start & ~in_read_q;
        ctl.fin   = rd_end & in_read_q;
        ctl.hold  = in_read_q | ctl.start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_read_q <= 1'b0;
            snap_q    <= '0;
        end else begin
            if (ctl.start) begin
                in_read_q <= 1'b1;
                snap_q    <= pack_status(summary, flags);
            end else if (ctl.fin) begin
                in_read_q <= 1'b0;
            end
        end
    end

    assign rd_data = snap_q;

    // R5
    snap_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_start && !in_read_q) |=> $stable(snap_q));

    // R8
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (snap_q[RSV_W-1:0] == '0));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (in_read_q && !rd_end) |=> in_read_q);

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtcirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              en_wr,
    input  logic [NSRC-1:0]   en_wdata,
    input  logic              hold_updates,
    input  logic              rd_start,
    input  logic              rd_end,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq_pull_low
);
    srcvec_t evts, flags, pends, en;
    rdctl_t  ctl;
    logic    summary;

    always_comb begin
        evts          = '0;
        evts[SRC_PER] = evt_periodic;
        evts[SRC_ALM] = evt_alarm;
        evts[SRC_UPD] = evt_update;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            rtcirq_flag_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .evt  (evts[gi]),
                .hold (ctl.hold),
                .fin  (ctl.fin),
                .flag (flags[gi]),
                .pend (pends[gi])
            );
        end
    endgenerate

    rtcirq_enable_reg u_en (
        .clk          (clk),
        .rst          (rst),
        .en_wr        (en_wr),
        .en_wdata     (en_wdata),
        .hold_updates (hold_updates),
        .en           (en)
    );

    assign summary = irq_summary(flags, en);

    rtcirq_read_ctrl u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .flags    (flags),
        .summary  (summary),
        .ctl      (ctl),
        .rd_data  (rd_data)
    );

    assign irq_pull_low = summary;

    // R4
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.fin && (pends == '0) && (evts == '0)) |=> (flags == '0 && !irq_pull_low));

    // R7
    enable_on_set_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !ctl.fin && ((flags & en_wdata & 3'b011) != '0)) |=> irq_pull_low);

    // R2
    idle_pin_released_chk: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq_pull_low);

endmodule

// File: tb/rtc_irq_flags_test.sv
module rtc_irq_flags_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evts = '0;
    logic       en_wr = 1'b0;
    logic [2:0] en_wdata = '0;
    logic       hold_updates = 1'b0;
    logic       rd_start = 1'b0;
    logic       rd_end = 1'b0;
    logic [7:0] rd_data;
    logic       irq_pull_low;

    always #2 clk = ~clk;   // 250 MHz

    rtc_irq_flags uut (
        .clk          (clk),
        .rst          (rst),
        .evt_periodic (evts[0]),
        .evt_alarm    (evts[1]),
        .evt_update   (evts[2]),
        .en_wr        (en_wr),
        .en_wdata     (en_wdata),
        .hold_updates (hold_updates),
        .rd_start     (rd_start),
        .rd_end       (rd_end),
        .rd_data      (rd_data),
        .irq_pull_low (irq_pull_low)
    );

    typedef struct {
        int         due;
        bit         is_irq;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare due items at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.is_irq) begin
                if (irq_pull_low !== e.val[0]) begin
                    failures++;
                    $display("FAIL %s irq_pull_low actual=%0b expected=%0b", e.tag, irq_pull_low, e.val[0]);
                end
            end else if (rd_data !== e.val) begin
                failures++;
                $display("FAIL %s rd_data actual=%02h expected=%02h", e.tag, rd_data, e.val);
            end
        end
    end

    // status byte from R1/R8/R10 layout
    function automatic logic [7:0] st(logic s, logic p, logic a, logic u);
        return {s, p, a, u, 4'b0000};
    endfunction

    task automatic push(bit is_irq, logic [7:0] v, string tag);
        exp_t e;
        e.due = cyc + 1; e.is_irq = is_irq; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic expect_irq(logic v, string tag);
        push(1'b1, {7'd0, v}, tag);
        @(negedge clk);
    endtask

    task automatic expect_rd(logic [7:0] v, string tag);
        push(1'b0, v, tag);
        @(negedge clk);
    endtask

    task automatic pulse(logic [2:0] m);
        @(negedge clk); evts = m;
        @(negedge clk); evts = '0;
    endtask

    task automatic set_en(logic [2:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic set_hold(logic v);
        @(negedge clk); hold_updates = v;
        @(negedge clk);
    endtask

    task automatic rd_begin(logic [2:0] m, logic [7:0] exp, string tag);
        @(negedge clk); rd_start = 1'b1; evts = m;
        push(1'b0, exp, tag);
        @(negedge clk); rd_start = 1'b0; evts = '0;
    endtask

    task automatic rd_finish(logic [2:0] m);
        @(negedge clk); rd_end = 1'b1; evts = m;
        @(negedge clk); rd_end = 1'b0; evts = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        expect_irq(1'b0, "R2 reset");
        rd_begin(3'b000, st(0,0,0,0), "R8 reset");
        rd_finish(3'b000);

        // flag set with enable off, then cleared by a read
        pulse(3'b001);
        expect_irq(1'b0, "R3 disabled flag no irq");
        rd_begin(3'b000, st(0,1,0,0), "R3 R10 periodic bit6");
        rd_finish(3'b000);
        rd_begin(3'b000, st(0,0,0,0), "R4 cleared");
        rd_finish(3'b000);

        pulse(3'b010);
        pulse(3'b100);
        rd_begin(3'b000, st(0,0,1,1), "R10 alarm bit5 update bit4");
        rd_finish(3'b000);

        // enable after flag set
        pulse(3'b010);
        expect_irq(1'b0, "R3 alarm flag, no enable");
        set_en(3'b010);
        expect_irq(1'b1, "R7 enable on set flag");
        rd_begin(3'b000, st(1,0,1,0), "R1 summary bit7");
        expect_irq(1'b1, "R5 irq held during read");
        rd_finish(3'b000);
        expect_irq(1'b0, "R4 irq released");

        // deferral and stability
        pulse(3'b001);
        rd_begin(3'b000, st(0,1,0,0), "R5 snapshot");
        pulse(3'b100);
        expect_rd(st(0,1,0,0), "R5 snapshot stable");
        rd_finish(3'b000);
        rd_begin(3'b000, st(0,0,0,1), "R6 mid-read event");
        rd_finish(3'b010);
        expect_irq(1'b1, "R6 release-cycle event");
        rd_begin(3'b000, st(1,0,1,0), "R6 release-cycle event");
        rd_finish(3'b000);
        rd_begin(3'b001, st(0,0,0,0), "R6 start-cycle event excluded");
        rd_finish(3'b000);
        rd_begin(3'b000, st(0,1,0,0), "R6 start-cycle event");
        rd_finish(3'b000);

        // hold_updates edge clears update enable
        set_en(3'b111);
        pulse(3'b100);
        expect_irq(1'b1, "R1 update irq");
        set_hold(1'b1);
        expect_irq(1'b0, "R9 hold rise");
        rd_begin(3'b000, st(0,0,0,1), "R9 flag kept");
        rd_finish(3'b000);
        set_hold(1'b0);
        pulse(3'b100);
        expect_irq(1'b0, "R9 update still disabled");
        @(negedge clk); en_wr = 1'b1; en_wdata = 3'b100; hold_updates = 1'b1;
        @(negedge clk); en_wr = 1'b0;
        expect_irq(1'b0, "R9 rise beats write");
        set_en(3'b100);
        expect_irq(1'b1, "R9 level does not block");
        rd_begin(3'b000, st(1,0,0,1), "R9 status");
        rd_finish(3'b000);
        set_hold(1'b0);

        // stray strobes
        pulse(3'b001);
        @(negedge clk); rd_end = 1'b1;
        @(negedge clk); rd_end = 1'b0;
        rd_begin(3'b000, st(0,1,0,0), "R11 stray release ignored");
        pulse(3'b010);
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        expect_rd(st(0,1,0,0), "R11 second start ignored");
        rd_finish(3'b000);
        rd_begin(3'b000, st(0,0,1,0), "R11 deferred after restart");
        rd_finish(3'b000);

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard %0d items unchecked actual=%0d expected=0", q.size(), q.size());
        end
        finish_run();
    end

endmodule